// File: doc/BRIEF.md
# Peripheral-to-Memory Transfer Sequencer

This block is the bus-master half of a peripheral data mover. A set of serial peripherals each raise a receive-ready and a transmit-ready line. For every channel (one peripheral, one direction) the channel engine reports whether the direction is enabled and whether its current transfer counter is nonzero. The block also supplies a memory pointer and a 2-bit unit size for the channel. The sequencer picks one eligible channel, requests the system bus, and waits for a grant while the bus is not stalled. It then moves exactly one data unit.

A receive unit takes two phases. In the first, the block reads the peripheral holding register through a dedicated bridge port. In the second, it writes memory on the system bus while flagging that memory must take its data from the bridge. A transmit unit takes one phase. The memory read address and the bridge write into the peripheral holding register are presented together, so the data read from memory lands in the peripheral at the end of that phase. A high bus-wait input holds any phase unchanged.

When a unit completes, a one-cycle advance strobe tagged with the channel index and direction tells the channel engine to step its pointer and counter.

Top module: `xfer_sequencer`

## Requirements
- R1: During and right after reset, bus_req, mst_oe, mst_active, mst_write, mem_from_bridge, br_sel, br_write and adv_strobe are all 0.
- R2: A channel is eligible only when its ready, enable and counter-nonzero inputs are all 1. An eligible channel raises bus_req on the cycle after the edge that sees it. Ready inputs without enable, or without a nonzero counter, have no effect. If the chosen channel stops being eligible before the transfer starts, bus_req drops on the following cycle.
- R3: No phase starts (mst_oe stays 0) until grant is 1 and bus_wait is 0 at the same clock edge.
- R4: Among eligible channels the one with the smallest key 2*p+d wins, where p is the peripheral index and d is 0 for receive and 1 for transmit. The lowest peripheral therefore wins, and receive beats transmit within a peripheral.
- R5: A receive unit is a bridge read phase (br_sel=1, br_write=0, mst_active=0) followed by a memory write phase (br_sel=0, mst_active=1, mst_write=1, mem_from_bridge=1). Without wait states it takes exactly two phase cycles.
- R6: A transmit unit is one phase with mst_active=1, mst_write=0, br_sel=1, br_write=1 and mem_from_bridge=0. Without wait states it takes exactly one phase cycle.
- R7: While bus_wait is 1 during a phase, that phase and all its address and control outputs stay unchanged. The phase completes on the first cycle with bus_wait at 0.
- R8: mst_oe is 1 exactly in the phase cycles of a transfer, only while grant is 1, and falls after the final phase completes with bus_wait at 0.
- R9: br_size and mst_size equal size bits [2p+1:2p] of the selected direction's size input. mst_addr equals the selected channel's pointer field [AW*p +: AW]. br_addr equals BR_BASE + p*BR_STRIDE + (RX_HOLD_OFS for receive, TX_HOLD_OFS for transmit); with the defaults this is 0x8000 + 0x400*p + 0x18 or 0x1C.
- R10: adv_strobe is 1 for exactly one cycle, namely the cycle in which the last phase of a unit completes. In that cycle adv_chan is p and adv_dir is d (1 = transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ready | input | N | Per-peripheral receive data ready |
| tx_ready | input | N | Per-peripheral transmit holding register free |
| rx_enable | input | N | Receive direction enabled by channel engine |
| tx_enable | input | N | Transmit direction enabled by channel engine |
| rx_cnt_nz | input | N | Receive current counter is nonzero |
| tx_cnt_nz | input | N | Transmit current counter is nonzero |
| rx_size | input | 2N | Receive unit size per peripheral (0 byte, 1 half, 2 word) |
| tx_size | input | 2N | Transmit unit size per peripheral |
| rx_ptr | input | N*AW | Receive memory pointer per peripheral |
| tx_ptr | input | N*AW | Transmit memory pointer per peripheral |
| grant | input | 1 | Arbiter grant |
| bus_wait | input | 1 | System bus wait (stall) |
| bus_req | output | 1 | Bus request to the arbiter |
| mst_oe | output | 1 | Master address and control outputs valid |
| mst_active | output | 1 | Memory access in this phase |
| mst_write | output | 1 | Memory access is a write |
| mst_addr | output | AW | Memory address |
| mst_size | output | 2 | Memory access size |
| mem_from_bridge | output | 1 | Memory takes write data from the bridge |
| br_sel | output | 1 | Bridge port select |
| br_write | output | 1 | Bridge port write (peripheral write) |
| br_addr | output | BAW | Bridge port peripheral address |
| br_size | output | 2 | Bridge port access size |
| adv_strobe | output | 1 | One-unit advance pulse to the channel engine |
| adv_chan | output | PW | Peripheral index of the advance |
| adv_dir | output | 1 | Direction of the advance (1 = transmit) |

## Verification
Directed patterns isolate single effects. Ready without enable, or with a zero counter, must leave the request low. A withheld grant must leave the output enable low. A receive and a transmit from different peripherals that are ready together must resolve by the priority key. A grant arriving together with a stall must not start a phase. Constrained random traffic then mixes all eight channels with random grant delay, random stall cycles and random counter refills. A reference model predicts the pick, the phase order, the addresses and sizes, and the completion count per unit. This separates a wrong priority from a wrong phase order or a phase that moves during a stall. Zero-wait runs also pin the exact two-phase and one-phase durations.

// File: rtl/xs_pkg.sv
// Shared types for the transfer sequencer.
// Assumes: one transfer in flight at a time.
package xs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // nothing selected
        ST_REQ  = 2'd1,   // channel latched, waiting for grant
        ST_PH1  = 2'd2,   // first (or only) phase
        ST_PH2  = 2'd3    // second phase of a receive unit
    } xs_state_e;

    localparam logic DIR_RX = 1'b0;
    localparam logic DIR_TX = 1'b1;
endpackage

// File: rtl/xs_picker.sv
// Fixed-priority channel picker.
// Key k = 2*p + d (d=1 transmit); the lowest set key wins.
// Assumes: eligibility vectors are already qualified by the top.
module xs_picker #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  rx_elig,
    input  logic [N-1:0]  tx_elig,
    output logic          any_elig,
    output logic [PW-1:0] pick_idx,
    output logic          pick_dir
);
    localparam int K = 2 * N;

    logic [K-1:0] keys;

    // Interleave the two directions so that key order equals priority order.
    for (genvar p = 0; p < N; p++) begin : g_keys
        assign keys[2*p]   = rx_elig[p];
        assign keys[2*p+1] = tx_elig[p];
    end

    // Scan from the top down so that the lowest set key is left standing.
    always_comb begin
        pick_idx = '0;
        pick_dir = 1'b0;
        for (int k = K - 1; k >= 0; k--) begin
            if (keys[k]) begin
                pick_idx = PW'(k / 2);
                pick_dir = k[0];
            end
        end
    end

    assign any_elig = |keys;
endmodule

// File: rtl/xs_route.sv
// Address and size routing for the latched channel.
// Assumes: idx < N; packed per-peripheral fields at fixed strides.
module xs_route #(
    parameter int          N           = 4,
    parameter int          AW          = 32,
    parameter int          BAW         = 16,
    parameter int          PW          = (N > 1) ? $clog2(N) : 1,
    parameter logic [15:0] BR_BASE     = 16'h8000,
    parameter logic [15:0] BR_STRIDE   = 16'h0400,
    parameter logic [15:0] RX_HOLD_OFS = 16'h0018,
    parameter logic [15:0] TX_HOLD_OFS = 16'h001C
) (
    input  logic [PW-1:0]   idx,
    input  logic            dir,
    input  logic [2*N-1:0]  rx_size,
    input  logic [2*N-1:0]  tx_size,
    input  logic [N*AW-1:0] rx_ptr,
    input  logic [N*AW-1:0] tx_ptr,
    output logic [1:0]      unit_size,
    output logic [AW-1:0]   mem_addr,
    output logic [BAW-1:0]  per_addr
);
    logic [BAW-1:0] slot_base;

    // Pick the size field and pointer of the latched channel.
    always_comb begin
        unit_size = dir ? tx_size[2*idx +: 2] : rx_size[2*idx +: 2];
        mem_addr  = dir ? tx_ptr[AW*idx +: AW] : rx_ptr[AW*idx +: AW];
    end

    // Holding-register address of the peripheral slot.
    always_comb begin
        slot_base = BAW'(BR_BASE) + BAW'(idx) * BAW'(BR_STRIDE);
        per_addr  = slot_base + (dir ? BAW'(TX_HOLD_OFS) : BAW'(RX_HOLD_OFS));
    end
endmodule

// File: rtl/xs_ctrl.sv
// Phase controller: latch a pick, request, run one or two phases.
// Assumes: the arbiter keeps grant high while bus_req is high once granted.
module xs_ctrl
    import xs_pkg::*;
#(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_elig,
    input  logic [PW-1:0] pick_idx,
    input  logic          pick_dir,
    input  logic          lat_elig,
    input  logic          grant,
    input  logic          bus_wait,
    output xs_state_e     state,
    output logic [PW-1:0] lat_idx,
    output logic          lat_dir,
    output logic          unit_done
);
    xs_state_e state_nx;

    // Completion: the last phase of the unit finishes without a stall.
    assign unit_done = !bus_wait &&
                       ((state == ST_PH1 && lat_dir == DIR_TX) || state == ST_PH2);

    // Next-state selection for the phase sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (any_elig) state_nx = ST_REQ;
            ST_REQ: begin
                if (!lat_elig)               state_nx = ST_IDLE;
                else if (grant && !bus_wait) state_nx = ST_PH1;
            end
            ST_PH1: if (!bus_wait) state_nx = (lat_dir == DIR_TX) ? ST_IDLE : ST_PH2;
            ST_PH2: if (!bus_wait) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Latch the winning channel once, when leaving idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_idx <= '0;
            lat_dir <= 1'b0;
        end else if (state == ST_IDLE && any_elig) begin
            lat_idx <= pick_idx;
            lat_dir <= pick_dir;
        end
    end

    // R3
    phase_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH1 && $past(state) == ST_REQ) |-> ($past(grant) && !$past(bus_wait)));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PH1 || state == ST_PH2) && bus_wait)
            |=> (state == $past(state) && $stable(lat_idx) && $stable(lat_dir)));

    // R10
    adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |=> !unit_done);
endmodule

// File: rtl/xfer_sequencer.sv
// Top of the transfer sequencer: qualifies ready lines, picks a channel,
// runs its bus phases and emits the advance strobe.
// Assumes: single outstanding unit; grant held while requested.
module xfer_sequencer
    import xs_pkg::*;
#(
    parameter int          N           = 4,
    parameter int          AW          = 32,
    parameter int          BAW         = 16,
    parameter logic [15:0] BR_BASE     = 16'h8000,
    parameter logic [15:0] BR_STRIDE   = 16'h0400,
    parameter logic [15:0] RX_HOLD_OFS = 16'h0018,
    parameter logic [15:0] TX_HOLD_OFS = 16'h001C,
    localparam int         PW          = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    rx_ready,
    input  logic [N-1:0]    tx_ready,
    input  logic [N-1:0]    rx_enable,
    input  logic [N-1:0]    tx_enable,
    input  logic [N-1:0]    rx_cnt_nz,
    input  logic [N-1:0]    tx_cnt_nz,
    input  logic [2*N-1:0]  rx_size,
    input  logic [2*N-1:0]  tx_size,
    input  logic [N*AW-1:0] rx_ptr,
    input  logic [N*AW-1:0] tx_ptr,
    input  logic            grant,
    input  logic            bus_wait,
    output logic            bus_req,
    output logic            mst_oe,
    output logic            mst_active,
    output logic            mst_write,
    output logic [AW-1:0]   mst_addr,
    output logic [1:0]      mst_size,
    output logic            mem_from_bridge,
    output logic            br_sel,
    output logic            br_write,
    output logic [BAW-1:0]  br_addr,
    output logic [1:0]      br_size,
    output logic            adv_strobe,
    output logic [PW-1:0]   adv_chan,
    output logic            adv_dir
);
    logic [N-1:0]   rx_elig, tx_elig;
    logic           any_elig, pick_dir, lat_dir, lat_elig, unit_done;
    logic [PW-1:0]  pick_idx, lat_idx;
    xs_state_e      state;
    logic [1:0]     unit_size;
    logic [AW-1:0]  mem_addr;
    logic [BAW-1:0] per_addr;
    logic           ph1, ph2;

    assign rx_elig  = rx_ready & rx_enable & rx_cnt_nz;
    assign tx_elig  = tx_ready & tx_enable & tx_cnt_nz;
    assign lat_elig = lat_dir ? tx_elig[lat_idx] : rx_elig[lat_idx];

    xs_picker #(.N(N), .PW(PW)) picker_i (
        .rx_elig (rx_elig),
        .tx_elig (tx_elig),
        .any_elig(any_elig),
        .pick_idx(pick_idx),
        .pick_dir(pick_dir)
    );

    xs_ctrl #(.PW(PW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_elig (any_elig),
        .pick_idx (pick_idx),
        .pick_dir (pick_dir),
        .lat_elig (lat_elig),
        .grant    (grant),
        .bus_wait (bus_wait),
        .state    (state),
        .lat_idx  (lat_idx),
        .lat_dir  (lat_dir),
        .unit_done(unit_done)
    );

    xs_route #(
        .N(N), .AW(AW), .BAW(BAW), .PW(PW),
        .BR_BASE(BR_BASE), .BR_STRIDE(BR_STRIDE),
        .RX_HOLD_OFS(RX_HOLD_OFS), .TX_HOLD_OFS(TX_HOLD_OFS)
    ) route_i (
        .idx      (lat_idx),
        .dir      (lat_dir),
        .rx_size  (rx_size),
        .tx_size  (tx_size),
        .rx_ptr   (rx_ptr),
        .tx_ptr   (tx_ptr),
        .unit_size(unit_size),
        .mem_addr (mem_addr),
        .per_addr (per_addr)
    );

    assign ph1 = (state == ST_PH1);
    assign ph2 = (state == ST_PH2);

    // Phase decode: receive = bridge read then memory write; transmit = both at once.
    always_comb begin
        bus_req         = (state != ST_IDLE);
        mst_oe          = ph1 || ph2;
        br_sel          = ph1;
        br_write        = ph1 && (lat_dir == DIR_TX);
        mst_active      = (ph1 && lat_dir == DIR_TX) || ph2;
        mst_write       = ph2;
        mem_from_bridge = ph2;
        mst_addr        = mst_active ? mem_addr  : '0;
        mst_size        = mst_active ? unit_size : 2'd0;
        br_addr         = br_sel     ? per_addr  : '0;
        br_size         = br_sel     ? unit_size : 2'd0;
        adv_strobe      = unit_done;
        adv_chan        = unit_done ? lat_idx : '0;
        adv_dir         = unit_done && lat_dir;
    end

    // R8
    oe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mst_oe |-> grant);

    // R5
    rx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_from_bridge && !$past(mem_from_bridge)) |-> $past(br_sel && !br_write));

    // R6
    tx_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel && br_write) |-> (mst_active && !mst_write && !mem_from_bridge));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!bus_req && !mst_oe && !br_sel && !adv_strobe));
endmodule

// File: tb/xfer_sequencer_tb_top.sv
// Self-checking bench: channel engine, arbiter and wait model plus reference checks.
module xfer_sequencer_tb_top;
    localparam int N = 4;
    localparam int K = 2 * N;
    localparam int AW = 32;
    localparam int BAW = 16;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [N-1:0]    rx_ready, tx_ready, rx_enable, tx_enable, rx_cnt_nz, tx_cnt_nz;
    logic [2*N-1:0]  rx_size, tx_size;
    logic [N*AW-1:0] rx_ptr, tx_ptr;
    logic            grant = 1'b0, bus_wait = 1'b0;
    logic            bus_req, mst_oe, mst_active, mst_write, mem_from_bridge;
    logic [AW-1:0]   mst_addr;
    logic [1:0]      mst_size, br_size;
    logic            br_sel, br_write, adv_strobe, adv_dir;
    logic [BAW-1:0]  br_addr;
    logic [PW-1:0]   adv_chan;

    // Channel engine model, key k = 2*p + d
    bit          rdy [K];
    bit          en  [K];
    int          cnt [K];
    logic [1:0]  sz  [K];
    logic [31:0] ptr [K];

    always_comb begin
        for (int p = 0; p < N; p++) begin
            rx_ready[p]  = rdy[2*p];
            tx_ready[p]  = rdy[2*p+1];
            rx_enable[p] = en[2*p];
            tx_enable[p] = en[2*p+1];
            rx_cnt_nz[p] = (cnt[2*p] != 0);
            tx_cnt_nz[p] = (cnt[2*p+1] != 0);
            rx_size[2*p +: 2] = sz[2*p];
            tx_size[2*p +: 2] = sz[2*p+1];
            rx_ptr[AW*p +: AW] = ptr[2*p];
            tx_ptr[AW*p +: AW] = ptr[2*p+1];
        end
    end

    xfer_sequencer #(.N(N), .AW(AW), .BAW(BAW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_ready(rx_ready), .tx_ready(tx_ready),
        .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_cnt_nz(rx_cnt_nz), .tx_cnt_nz(tx_cnt_nz),
        .rx_size(rx_size), .tx_size(tx_size),
        .rx_ptr(rx_ptr), .tx_ptr(tx_ptr),
        .grant(grant), .bus_wait(bus_wait),
        .bus_req(bus_req), .mst_oe(mst_oe), .mst_active(mst_active),
        .mst_write(mst_write), .mst_addr(mst_addr), .mst_size(mst_size),
        .mem_from_bridge(mem_from_bridge),
        .br_sel(br_sel), .br_write(br_write), .br_addr(br_addr), .br_size(br_size),
        .adv_strobe(adv_strobe), .adv_chan(adv_chan), .adv_dir(adv_dir)
    );

    int n_checks = 0, n_fail = 0, n_units = 0;
    bit finished = 1'b0;

    // Bus model knobs
    bit gnt_block = 1'b0;
    int gnt_pct = 100;
    int wait_pct = 0;

    // Monitor state
    int edge_pick = -1, cur_k = -1;
    bit prev_req = 0, prev_hold = 0, prev_adv = 0, saw_bread = 0;
    int phase_done = 0, phase_all = 0;
    int last_adv_k = -1, last_phase_all = 0;
    logic [AW-1:0]  p_mst_addr;
    logic [BAW-1:0] p_br_addr;
    logic           p_br_sel, p_mst_active, p_mst_write;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit elig(input int k);
        return rdy[k] && en[k] && (cnt[k] != 0);
    endfunction

    function automatic int prio();
        for (int k = 0; k < K; k++) if (elig(k)) return k;
        return -1;
    endfunction

    function automatic logic [BAW-1:0] exp_br_addr(input int k);
        return 16'h8000 + 16'(k / 2) * 16'h0400 + ((k % 2) ? 16'h001C : 16'h0018);
    endfunction

    function automatic int unit_bytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    // Compare outputs against the reference; update the channel model on advance.
    task automatic monitor();
        bit phase;
        bit rx;
        phase = br_sel || mst_active;
        if (bus_req && !prev_req) begin
            cur_k = edge_pick;
            saw_bread = 0;
            phase_done = 0;
            phase_all = 0;
            chk(cur_k >= 0, "R2", "request without eligible channel", cur_k, 0);
        end
        rx = (cur_k >= 0) && (cur_k % 2 == 0);
        chk(mst_oe == phase, "R8", "oe vs phase", mst_oe, phase);
        if (mst_oe) chk(grant, "R8", "oe without grant", grant, 1);
        if (prev_hold) begin
            chk(br_sel == p_br_sel && mst_active == p_mst_active && mst_write == p_mst_write,
                "R7", "phase moved during wait", {br_sel, mst_active, mst_write},
                {p_br_sel, p_mst_active, p_mst_write});
            chk(mst_addr == p_mst_addr && br_addr == p_br_addr, "R7", "address moved during wait",
                mst_addr, p_mst_addr);
        end
        if (br_sel && cur_k >= 0) begin
            chk(br_addr == exp_br_addr(cur_k), "R9", "br_addr", br_addr, exp_br_addr(cur_k));
            chk(br_size == sz[cur_k], "R9", "br_size", br_size, sz[cur_k]);
            chk(br_write == !rx, "R5", "bridge direction", br_write, !rx);
            if (!br_write) saw_bread = 1;
        end
        if (mst_active && cur_k >= 0) begin
            chk(mst_addr == ptr[cur_k], "R9", "mst_addr", mst_addr, ptr[cur_k]);
            chk(mst_size == sz[cur_k], "R9", "mst_size", mst_size, sz[cur_k]);
            chk(mst_write == rx && mem_from_bridge == rx, "R6", "memory direction",
                {mst_write, mem_from_bridge}, {rx, rx});
            if (rx) chk(saw_bread && !br_sel, "R5", "memory write before bridge read",
                        {saw_bread, br_sel}, 2'b10);
        end
        if (phase) phase_all++;
        if (phase && !bus_wait) phase_done++;
        if (prev_adv) chk(!adv_strobe, "R10", "advance longer than one cycle", adv_strobe, 0);
        if (adv_strobe) begin
            int got;
            got = 2 * int'(adv_chan) + int'(adv_dir);
            chk(got == cur_k, "R10", "advance tag", got, cur_k);
            chk(phase_done == (rx ? 2 : 1), rx ? "R5" : "R6", "completed phases",
                phase_done, rx ? 2 : 1);
            if (cur_k >= 0) begin
                cnt[cur_k] = cnt[cur_k] - 1;
                rdy[cur_k] = 0;
                ptr[cur_k] = ptr[cur_k] + 32'(unit_bytes(sz[cur_k]));
            end
            last_adv_k = got;
            last_phase_all = phase_all;
            n_units++;
        end
        prev_req = bus_req;
        prev_hold = phase && bus_wait;
        prev_adv = adv_strobe;
        p_mst_addr = mst_addr;
        p_br_addr = br_addr;
        p_br_sel = br_sel;
        p_mst_active = mst_active;
        p_mst_write = mst_write;
    endtask

    // One clock: note the pick the next edge sees, drive the bus model, then check.
    task automatic tick();
        edge_pick = prio();
        @(negedge clk);
        grant = bus_req && !gnt_block && (grant || ($urandom % 100) < gnt_pct);
        bus_wait = ($urandom % 100) < wait_pct;
        #1;
        monitor();
    endtask

    task automatic run_idle(input int max);
        for (int i = 0; i < max; i++) begin
            tick();
            if (!bus_req && prio() < 0) break;
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        for (int k = 0; k < K; k++) begin
            rdy[k] = 0; en[k] = 0; cnt[k] = 0;
            sz[k] = 2'(k % 3);
            ptr[k] = 32'h2000_0000 + 32'(k) * 32'h100;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk(!bus_req && !mst_oe && !mst_active && !mst_write && !mem_from_bridge &&
            !br_sel && !br_write && !adv_strobe, "R1", "outputs in reset",
            {bus_req, mst_oe, br_sel, adv_strobe}, 0);
        rst_n = 1'b1;
        tick();
        chk(!bus_req && !mst_oe && !adv_strobe, "R1", "outputs after reset",
            {bus_req, mst_oe, adv_strobe}, 0);

        // R2: ready without enable, then enable with zero count: no request
        for (int k = 0; k < K; k++) begin rdy[k] = 1; cnt[k] = 3; end
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!bus_req, "R2", "request with enables off", bus_req, 0);
        end
        for (int k = 0; k < K; k++) begin en[k] = 1; cnt[k] = 0; end
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!bus_req, "R2", "request with zero counters", bus_req, 0);
        end

        // R4: peripheral 1 receive against peripheral 0 transmit, no waits
        for (int k = 0; k < K; k++) rdy[k] = 0;
        cnt[1] = 1; cnt[2] = 1; rdy[1] = 1; rdy[2] = 1;
        last_adv_k = -1;
        for (int i = 0; i < 20 && last_adv_k < 0; i++) tick();
        chk(last_adv_k == 1, "R4", "priority peripheral0 tx over peripheral1 rx", last_adv_k, 1);
        chk(last_phase_all == 1, "R6", "tx phase cycles without wait", last_phase_all, 1);
        last_adv_k = -1;
        for (int i = 0; i < 20 && last_adv_k < 0; i++) tick();
        chk(last_adv_k == 2, "R4", "remaining peripheral1 rx served", last_adv_k, 2);
        chk(last_phase_all == 2, "R5", "rx phase cycles without wait", last_phase_all, 2);
        run_idle(10);

        // R3 and R2: grant withheld, then the channel is disabled before grant
        gnt_block = 1;
        cnt[4] = 2; rdy[4] = 1;
        tick();
        tick();
        chk(bus_req, "R2", "request raised", bus_req, 1);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk(!mst_oe && !br_sel, "R3", "phase without grant", mst_oe, 0);
        end
        en[4] = 0;
        tick();
        chk(!bus_req, "R2", "request dropped after disable", bus_req, 0);
        en[4] = 1;
        gnt_block = 0;

        // R3 and R7: grant arrives while the bus is stalled
        wait_pct = 100;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(!mst_oe, "R3", "phase started under wait", mst_oe, 0);
        end
        wait_pct = 0;
        run_idle(20);
        chk(cnt[4] == 1, "R10", "one unit per advance", cnt[4], 1);

        // Random traffic with grant delay and stalls
        gnt_pct = 40;
        wait_pct = 30;
        for (int it = 0; it < 4000; it++) begin
            tick();
            for (int k = 0; k < K; k++) begin
                if (!rdy[k] && ($urandom % 8) == 0) rdy[k] = 1;
                if (cnt[k] == 0 && ($urandom % 16) == 0) cnt[k] = 1 + int'($urandom % 5);
            end
        end
        gnt_pct = 100;
        wait_pct = 0;
        run_idle(50);
        chk(n_units > 50, "R10", "units completed in random run", n_units, 51);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule